// File: doc/BRIEF.md
# Boost PFC Mode Sequencer

This block supervises a boost power-factor-correction controller. Every cycle it reads a set of synchronous single-bit comparator flags covering the supply rail, the enable/overvoltage pin, the brown-out pin, the feedback node, the compensation node and the current-sense limit. From these it decides which of six operating modes the controller occupies. From the mode it drives the power-switch gate enable, a request to discharge the compensation node, the internal bias enable, and a 3-bit mode code.

Brown-out detection and undervoltage detection each use a different threshold before start-up than after it. The block tracks whether the converter has started and picks the matching flag. Leaving the running modes towards sleep or standby is never immediate. The block first drains the compensation node below its start level, so that the next start-up goes through a soft start.

Overvoltage and peak-current faults are two faults that clear by themselves. They gate the switch off in the same cycle the flag rises, because the gate output is qualified combinationally by those flags. They then hold a registered fault mode until the flag releases.

All control pins are plain levels. The block has no data stream, so it has no valid/ready handshake.

Top module: `pfc_mode_seq`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, the mode code is 0 (sleep) and gate_en, comp_dis and bias_en are all low.
- R2: Mode codes are sleep=0, standby=1, soft-start=2, run=3, overvoltage hold=4 and current limit=5. bias_en is high in every mode except settled sleep.
- R3: Sleep is chosen whenever en_sleep is high. Before start-up, a low vcc_on also selects sleep. Once running, only vcc_uv high does so, and vcc_on low is then ignored.
- R4: Before start-up a brown-out means bo_en is low. Once running, it means bo_run is low, and bo_en low has no effect. Either a brown-out or fb_ok low selects standby.
- R5: From sleep or standby, soft-start is entered only when no sleep or standby condition holds and comp_low is high. If comp_low is low, the block waits in standby.
- R6: When sleep or standby is selected from soft-start, run, overvoltage hold or current limit, the mode code shows the target. During the drain, comp_dis and bias_en are high and gate_en is low. The block settles at the first clock edge that sees comp_low high, after which comp_dis falls.
- R7: Soft-start lasts exactly SS_CYCLES clock edges and then moves to run, provided no fault intervenes.
- R8: From soft-start or run, en_ovp high enters overvoltage hold. The hold is kept while en_ovp_rst is low, even after en_ovp falls. It is left when en_ovp_rst is high.
- R9: From soft-start or run, ipk_trip high enters current limit. When the flag clears, the block resumes run if soft-start had completed, and resumes soft-start otherwise.
- R10: gate_en is low in the same cycle in which en_ovp or ipk_trip is high, with no wait for a clock edge.
- R11: When several conditions coincide, the priority is sleep, then standby, then overvoltage, then current limit.
- R12: gate_en can be high only in soft-start or run, and never while a drain is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vcc_on | input | 1 | Supply above turn-on level |
| vcc_uv | input | 1 | Supply below undervoltage level |
| en_sleep | input | 1 | Enable pin below sleep level |
| en_ovp | input | 1 | Enable pin above overvoltage level |
| en_ovp_rst | input | 1 | Enable pin below overvoltage reset level |
| bo_en | input | 1 | Brown-out pin above start-up enable level |
| bo_run | input | 1 | Brown-out pin above running level |
| fb_ok | input | 1 | Feedback above open-loop level |
| comp_low | input | 1 | Compensation below start level |
| ipk_trip | input | 1 | Peak current limit exceeded |
| gate_en | output | 1 | Gate driver enable |
| comp_dis | output | 1 | Compensation discharge request |
| bias_en | output | 1 | Internal bias enable |
| mode | output | 3 | Current mode code |

## Verification
The functions most likely to fall in the same cycle are overvoltage entry and current-limit entry. Both can arise while running, and both gate the switch off at once. The bench raises en_ovp and ipk_trip on the same falling edge while the block is in run. It then expects gate_en low before the next rising edge and overvoltage hold, not current limit, after it. Next it releases the overvoltage band while keeping ipk_trip high, and expects current limit to take over. A second collision raises en_sleep and drops fb_ok together, and the block must drain towards sleep rather than standby.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
  typedef enum logic [2:0] {
    M_SLEEP = 3'd0,
    M_STBY  = 3'd1,
    M_SOFT  = 3'd2,
    M_RUN   = 3'd3,
    M_OVH   = 3'd4,
    M_ILIM  = 3'd5
  } mode_e;

  function automatic logic is_active(mode_e m);
    return (m == M_SOFT) || (m == M_RUN) || (m == M_OVH) || (m == M_ILIM);
  endfunction
endpackage

// File: rtl/pfc_cond_eval.sv
module pfc_cond_eval (
  input  logic started,
  input  logic vcc_on,
  input  logic vcc_uv,
  input  logic en_sleep,
  input  logic bo_en,
  input  logic bo_run,
  input  logic fb_ok,
  output logic go_sleep,
  output logic go_stby
);
  logic supply_bad;
  logic brownout;

  // Threshold choice depends on whether the converter has started (R3, R4)
  always_comb begin
    supply_bad = started ? vcc_uv  : !vcc_on;
    brownout   = started ? !bo_run : !bo_en;
    go_sleep   = en_sleep || supply_bad;
    go_stby    = !fb_ok || brownout;
  end
endmodule

// File: rtl/pfc_ss_timer.sv
module pfc_ss_timer #(
  parameter int SS_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic in_soft,
  input  logic in_run,
  output logic ss_last,
  output logic ss_done
);
  localparam int CW = (SS_CYCLES > 1) ? $clog2(SS_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SS_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (in_soft && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      if (in_run) done_q <= 1'b1;
    end
  end

  assign ss_last = in_soft && (cnt_q == LAST);
  assign ss_done = done_q;

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_cnt_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !in_soft && !in_run && !active |=> cnt_q == '0);
endmodule

// File: rtl/pfc_mode_fsm.sv
module pfc_mode_fsm
  import pfc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  go_sleep,
  input  logic  go_stby,
  input  logic  en_ovp,
  input  logic  en_ovp_rst,
  input  logic  comp_low,
  input  logic  ipk_trip,
  input  logic  ss_last,
  input  logic  ss_done,
  output mode_e st,
  output logic  drain,
  output logic  active
);
  mode_e st_q, st_d;
  logic  drain_q, drain_d;
  mode_e resume;

  assign resume = ss_done ? M_RUN : M_SOFT;

  always_comb begin
    st_d    = st_q;
    drain_d = drain_q;
    if (drain_q) begin
      if (go_sleep) st_d = M_SLEEP;         // upgrade target (R11)
      if (comp_low) drain_d = 1'b0;         // settle (R6)
    end else begin
      unique case (st_q)
        M_SLEEP: begin
          if (!go_sleep) st_d = (!go_stby && comp_low) ? M_SOFT : M_STBY;
        end
        M_STBY: begin
          if (go_sleep)                   st_d = M_SLEEP;
          else if (!go_stby && comp_low)  st_d = M_SOFT;
        end
        default: begin
          if (go_sleep) begin
            st_d = M_SLEEP; drain_d = 1'b1;
          end else if (go_stby) begin
            st_d = M_STBY;  drain_d = 1'b1;
          end else if (en_ovp) begin
            st_d = M_OVH;
          end else if (st_q == M_OVH) begin
            if (en_ovp_rst) st_d = ipk_trip ? M_ILIM : resume;
          end else if (ipk_trip) begin
            st_d = M_ILIM;
          end else if (st_q == M_ILIM) begin
            st_d = resume;
          end else if (st_q == M_SOFT && ss_last) begin
            st_d = M_RUN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= M_SLEEP;
      drain_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      drain_q <= drain_d;
    end
  end

  assign st     = st_q;
  assign drain  = drain_q;
  assign active = is_active(st_q) && !drain_q;

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_q == M_SLEEP && !drain_q));
  p_ovh_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (active && st_q == M_OVH && !en_ovp_rst && !go_sleep && !go_stby) |=> st_q == M_OVH);
  p_drain_target_r6: assert property (@(posedge clk) disable iff (rst)
    drain_q |-> (st_q == M_SLEEP || st_q == M_STBY));
  p_sleep_first_r11: assert property (@(posedge clk) disable iff (rst)
    (active && go_sleep) |=> (st_q == M_SLEEP && drain_q));
endmodule

// File: rtl/pfc_out_dec.sv
module pfc_out_dec
  import pfc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mode_e      st,
  input  logic       drain,
  input  logic       active,
  input  logic       en_ovp,
  input  logic       ipk_trip,
  output logic       gate_en,
  output logic       comp_dis,
  output logic       bias_en,
  output logic [2:0] mode
);
  logic switching;

  always_comb begin
    switching = active && (st == M_SOFT || st == M_RUN);
    gate_en   = switching && !en_ovp && !ipk_trip;   // immediate block (R10)
    comp_dis  = drain;
    bias_en   = drain || (st != M_SLEEP);
    mode      = st;
  end

  p_gate_fault_r10: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> (!en_ovp && !ipk_trip));
  p_gate_mode_r12: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> ((mode == 3'd2 || mode == 3'd3) && !comp_dis));
  p_drain_bias_r6: assert property (@(posedge clk) disable iff (rst)
    comp_dis |-> (bias_en && !gate_en));
  p_sleep_bias_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && !comp_dis) |-> !bias_en);
endmodule

// File: rtl/pfc_mode_seq.sv
module pfc_mode_seq
  import pfc_seq_pkg::*;
#(
  parameter int SS_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_on,
  input  logic       vcc_uv,
  input  logic       en_sleep,
  input  logic       en_ovp,
  input  logic       en_ovp_rst,
  input  logic       bo_en,
  input  logic       bo_run,
  input  logic       fb_ok,
  input  logic       comp_low,
  input  logic       ipk_trip,
  output logic       gate_en,
  output logic       comp_dis,
  output logic       bias_en,
  output logic [2:0] mode
);
  mode_e st;
  logic  drain, active, started;
  logic  go_sleep, go_stby;
  logic  ss_last, ss_done;

  assign started = active || drain;

  pfc_cond_eval u_eval (
    .started (started),
    .vcc_on  (vcc_on),
    .vcc_uv  (vcc_uv),
    .en_sleep(en_sleep),
    .bo_en   (bo_en),
    .bo_run  (bo_run),
    .fb_ok   (fb_ok),
    .go_sleep(go_sleep),
    .go_stby (go_stby)
  );

  pfc_ss_timer #(.SS_CYCLES(SS_CYCLES)) u_ss (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .in_soft(active && st == M_SOFT),
    .in_run (active && st == M_RUN),
    .ss_last(ss_last),
    .ss_done(ss_done)
  );

  pfc_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .go_sleep  (go_sleep),
    .go_stby   (go_stby),
    .en_ovp    (en_ovp),
    .en_ovp_rst(en_ovp_rst),
    .comp_low  (comp_low),
    .ipk_trip  (ipk_trip),
    .ss_last   (ss_last),
    .ss_done   (ss_done),
    .st        (st),
    .drain     (drain),
    .active    (active)
  );

  pfc_out_dec u_out (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .drain   (drain),
    .active  (active),
    .en_ovp  (en_ovp),
    .ipk_trip(ipk_trip),
    .gate_en (gate_en),
    .comp_dis(comp_dis),
    .bias_en (bias_en),
    .mode    (mode)
  );
endmodule

// File: tb/tb_pfc_mode_seq.sv
`timescale 1ns/1ps
module tb_pfc_mode_seq;
  localparam int SS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_on = 0, vcc_uv = 0, en_sleep = 0, en_ovp = 0, en_ovp_rst = 1;
  logic bo_en = 0, bo_run = 0, fb_ok = 0, comp_low = 0, ipk_trip = 0;
  logic gate_en, comp_dis, bias_en;
  logic [2:0] mode;

  // staged stimulus, applied at falling edges by the driver
  logic s_vcc_on = 0, s_vcc_uv = 0, s_en_sleep = 0, s_en_ovp = 0, s_en_ovp_rst = 1;
  logic s_bo_en = 0, s_bo_run = 0, s_fb_ok = 0, s_comp_low = 0, s_ipk = 0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] m;
    logic       g;
    logic       d;
    logic       b;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  pfc_mode_seq #(.SS_CYCLES(SS)) dut (
    .clk(clk), .rst(rst), .vcc_on(vcc_on), .vcc_uv(vcc_uv), .en_sleep(en_sleep),
    .en_ovp(en_ovp), .en_ovp_rst(en_ovp_rst), .bo_en(bo_en), .bo_run(bo_run),
    .fb_ok(fb_ok), .comp_low(comp_low), .ipk_trip(ipk_trip),
    .gate_en(gate_en), .comp_dis(comp_dis), .bias_en(bias_en), .mode(mode)
  );

  task automatic compare(string tag, logic [2:0] m, logic g, logic d, logic b);
    checks++;
    if (mode !== m || gate_en !== g || comp_dis !== d || bias_en !== b) begin
      errors++;
      $display("FAIL %s: got mode=%0d gate=%b dis=%b bias=%b, expected mode=%0d gate=%b dis=%b bias=%b",
               tag, mode, gate_en, comp_dis, bias_en, m, g, d, b);
    end
  endtask

  // monitor: scores the state reached after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.tag, e.m, e.g, e.d, e.b);
    end
  end

  // driver: apply staged inputs, queue expectation for next edge
  task automatic step(string tag, logic [2:0] m, logic g, logic d, logic b,
                      bit now_gate_off = 1'b0);
    exp_t e;
    @(negedge clk);
    vcc_on = s_vcc_on; vcc_uv = s_vcc_uv; en_sleep = s_en_sleep;
    en_ovp = s_en_ovp; en_ovp_rst = s_en_ovp_rst; bo_en = s_bo_en;
    bo_run = s_bo_run; fb_ok = s_fb_ok; comp_low = s_comp_low; ipk_trip = s_ipk;
    if (now_gate_off) begin
      #1;
      checks++;
      if (gate_en !== 1'b0) begin
        errors++;
        $display("FAIL R10 %s: gate_en=%b before edge, expected 0", tag, gate_en);
      end
    end
    e.m = m; e.g = g; e.d = d; e.b = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic soft_to_run(string tag);
    for (int i = 0; i < SS - 1; i++) step({tag, " R7 soft"}, 3'd2, 1, 0, 1);
    step({tag, " R7 run"}, 3'd3, 1, 0, 1);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 compare("R1 in reset", 3'd0, 0, 0, 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #2 compare("R1 after reset", 3'd0, 0, 0, 0);

    // R5: all good except pre-biased compensation -> standby wait
    s_vcc_on = 1; s_bo_en = 1; s_bo_run = 1; s_fb_ok = 1; s_comp_low = 0;
    step("R5 prebias to standby", 3'd1, 0, 0, 1);
    step("R5 prebias holds", 3'd1, 0, 0, 1);
    s_comp_low = 1;
    step("R5 start", 3'd2, 1, 0, 1);
    soft_to_run("first");

    // R4: running uses run-level flag
    s_bo_en = 0;
    step("R4 enable level ignored while running", 3'd3, 1, 0, 1);
    s_bo_run = 0; s_comp_low = 0;
    step("R6 drain to standby", 3'd1, 0, 1, 1);
    step("R6 drain waits", 3'd1, 0, 1, 1);
    s_comp_low = 1;
    step("R6 settle standby", 3'd1, 0, 0, 1);
    s_bo_run = 1;
    step("R4 enable level before start", 3'd1, 0, 0, 1);
    s_bo_en = 1;
    step("R5 restart", 3'd2, 1, 0, 1);
    soft_to_run("second");

    // R8 overvoltage hysteresis
    s_en_ovp = 1; s_en_ovp_rst = 0;
    step("R8 enter hold", 3'd4, 0, 0, 1, 1'b1);
    s_en_ovp = 0;
    step("R8 hold in band", 3'd4, 0, 0, 1);
    s_en_ovp_rst = 1;
    step("R8 release to run", 3'd3, 1, 0, 1);

    // R11 overvoltage beats current limit
    s_en_ovp = 1; s_en_ovp_rst = 0; s_ipk = 1;
    step("R11 ovp over ipk", 3'd4, 0, 0, 1, 1'b1);
    s_en_ovp = 0; s_en_ovp_rst = 1;
    step("R9 ipk after ovp release", 3'd5, 0, 0, 1);
    s_ipk = 0;
    step("R9 resume run", 3'd3, 1, 0, 1);

    // R11 sleep beats standby
    s_en_sleep = 1; s_fb_ok = 0; s_comp_low = 0;
    step("R11 sleep over standby", 3'd0, 0, 1, 1);
    s_comp_low = 1;
    step("R2 settled sleep bias off", 3'd0, 0, 0, 0);

    // direct start from sleep, then current limit during soft-start
    s_en_sleep = 0; s_fb_ok = 1;
    step("R5 start from sleep", 3'd2, 1, 0, 1);
    step("R7 soft", 3'd2, 1, 0, 1);
    s_ipk = 1;
    step("R9 limit in soft", 3'd5, 0, 0, 1, 1'b1);
    s_ipk = 0;
    step("R9 resume soft", 3'd2, 1, 0, 1);

    // R3 thresholds
    s_vcc_on = 0;
    step("R3 turn-on ignored running", 3'd2, 1, 0, 1);
    s_vcc_uv = 1;
    step("R3 undervoltage drain", 3'd0, 0, 1, 1);
    step("R3 settle sleep", 3'd0, 0, 0, 0);
    s_vcc_uv = 0;
    step("R3 turn-on needed before start", 3'd0, 0, 0, 0);
    s_vcc_on = 1;
    step("R5 wake", 3'd2, 1, 0, 1);

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule